// File: doc/BRIEF.md
# Transmit Head-of-Line Flush Controller

This block sits between a transmit cell FIFO and the transmit master of a multi-PHY UTOPIA Level 2 port. It watches the cell at the head of the FIFO. When the master drives the address of that cell's target PHY, a timeout counter starts from zero. The counter steps on every transmit clock. If the PHY reports cell-available (CLAV) first, the block grants the send. If the counter reaches the programmed limit first, the block pops the cell with a one-cycle discard strobe, so a silent PHY cannot block the queue.

A port-disable bitmap works alongside the timer. While flushing is enabled, a head cell addressed to a PHY whose bit is set is discarded at once and without fuss. Such a discard does not raise the timeout indication that feeds the transmit status logic.

The block samples the configuration once, when a new head cell appears, and holds it for that cell's whole life. A limit of zero with flushing enabled is a configuration error. In that case the timer never fires, but the port-disable filter still works.

Top module: `utx_hol_flush`

## Requirements
- R1: During and right after reset, `drop_o`, `drop_tmo_o` and `send_ok_o` are low.
- R2: The timeout counter restarts from zero only when `addr_phase` is high and `poll_phy` equals the head cell's PHY. Address phases for any other PHY leave it running.
- R3: With flushing enabled and limit L ≥ 1, let the last target address phase be sampled at edge a, with no CLAV sampled after it. Then `drop_o` and `drop_tmo_o` are high in the cycle that follows edge a+L+1.
- R4: A CLAV sampled after the target address phase, and before the timeout, raises `send_ok_o` on the next cycle. `send_ok_o` stays high until `head_pop` is sampled high.
- R5: With `cfg_flush_en` low at cell arrival, the block never discards that cell. It neither times the cell out nor applies the bitmap to it.
- R6: With flushing enabled and `cfg_limit` equal to zero at cell arrival, the block never times that cell out.
- R7: With flushing enabled, bit x of `cfg_port_off` set, and a head cell for PHY x sampled while the block is idle, `drop_o` is high on the next cycle. No address phase is needed for this.
- R8: `drop_tmo_o` is high only together with a timeout discard. It stays low on bitmap discards.
- R9: `drop_o` is a one-cycle strobe, and the FIFO pops on it. The next head cell is accepted on the cycle after the strobe.
- R10: The enable, limit and port-disable values that apply to a cell are the ones present when the block accepted it. Later changes take effect from the next cell.
- R11: `drop_o` and `send_ok_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UTOPIA transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_flush_en | input | 1 | Enables the timeout flush and the port-disable filter |
| cfg_limit | input | 16 | Timeout compare value |
| cfg_port_off | input | 8 | Per-PHY disable bitmap, bit x for PHY x |
| head_valid | input | 1 | FIFO head holds a cell |
| head_phy | input | 3 | Target PHY of the head cell |
| head_pop | input | 1 | Master has taken the granted head cell |
| addr_phase | input | 1 | Master is driving a PHY address this cycle |
| poll_phy | input | 3 | PHY address driven by the master |
| clav | input | 1 | Cell-available from the addressed PHY |
| drop_o | output | 1 | Discard strobe, pops the FIFO head |
| drop_tmo_o | output | 1 | Discard was caused by timeout (status event) |
| send_ok_o | output | 1 | Head cell may be sent |

## Verification
The assertions assume the following. `head_pop` is only raised while `send_ok_o` is high. The FIFO pops its head on every `drop_o` strobe. The head PHY of a given cell does not change until that cell leaves. The bench keeps to these rules: its FIFO model pops only on the strobe or on its own `head_pop`, and it raises `head_pop` only from the grant it saw. Configuration, polling addresses and CLAV are otherwise free-running. In one phase the configuration even changes on every cycle.

// File: rtl/utx_hol_pkg.sv
package utx_hol_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_COUNT = 3'd2,
    ST_READY = 3'd3,
    ST_DROP  = 3'd4
  } hol_st_e;
endpackage

// File: rtl/utx_hol_snap.sv
module utx_hol_snap #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3,
  parameter int NPORT  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              en_i,
  input  logic [CNT_W-1:0]  lim_i,
  input  logic [NPORT-1:0]  off_i,
  input  logic [ADDR_W-1:0] phy_i,
  output logic              off_now,
  output logic              en_q,
  output logic [CNT_W-1:0]  lim_q,
  output logic [ADDR_W-1:0] phy_q
);
  logic bit_hit;

  // addresses beyond the bitmap never match a bit
  always_comb begin
    bit_hit = 1'b0;
    for (int i = 0; i < NPORT; i++) begin
      if (phy_i == ADDR_W'(i)) bit_hit = off_i[i];
    end
  end

  assign off_now = en_i && bit_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      lim_q <= '0;
      phy_q <= '0;
    end else if (load) begin
      en_q  <= en_i;
      lim_q <= lim_i;
      phy_q <= phy_i;
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(en_q) && $stable(lim_q) && $stable(phy_q)));
endmodule

// File: rtl/utx_hol_timer.sv
module utx_hol_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic             en,
  input  logic [CNT_W-1:0] lim,
  output logic             hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                          cnt <= '0;
    else if (clr)                     cnt <= '0;
    else if (run && cnt != CNT_MAX)   cnt <= cnt + 1'b1;
  end

  // zero limit is a configuration error: compare is suppressed
  assign hit = en && (lim != '0) && (cnt == lim);

  p_clr_r2: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt == '0);
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (run && !clr && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/utx_hol_flush.sv
module utx_hol_flush
  import utx_hol_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3,
  parameter int NPORT  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_flush_en,
  input  logic [CNT_W-1:0]  cfg_limit,
  input  logic [NPORT-1:0]  cfg_port_off,
  input  logic              head_valid,
  input  logic [ADDR_W-1:0] head_phy,
  input  logic              head_pop,
  input  logic              addr_phase,
  input  logic [ADDR_W-1:0] poll_phy,
  input  logic              clav,
  output logic              drop_o,
  output logic              drop_tmo_o,
  output logic              send_ok_o
);
  hol_st_e            st, nxt;
  logic               load, clr, tmo_n, tgt_addr, hit, off_now;
  logic               en_q;
  logic [CNT_W-1:0]   lim_q;
  logic [ADDR_W-1:0]  phy_q;

  utx_hol_snap #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .NPORT(NPORT)) u_snap (
    .clk(clk), .rst(rst), .load(load), .en_i(cfg_flush_en), .lim_i(cfg_limit),
    .off_i(cfg_port_off), .phy_i(head_phy), .off_now(off_now),
    .en_q(en_q), .lim_q(lim_q), .phy_q(phy_q)
  );

  utx_hol_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .clr(clr), .run(st == ST_COUNT),
    .en(en_q), .lim(lim_q), .hit(hit)
  );

  assign tgt_addr = addr_phase && (poll_phy == phy_q);

  always_comb begin
    nxt   = st;
    load  = 1'b0;
    clr   = 1'b0;
    tmo_n = 1'b0;
    case (st)
      ST_IDLE: if (head_valid) begin
        load = 1'b1;
        nxt  = off_now ? ST_DROP : ST_ARMED;
      end
      ST_ARMED: if (tgt_addr) begin
        clr = 1'b1;
        nxt = ST_COUNT;
      end
      ST_COUNT: begin
        if (clav)          nxt = ST_READY;
        else if (tgt_addr) clr = 1'b1;
        else if (hit) begin
          nxt   = ST_DROP;
          tmo_n = 1'b1;
        end
      end
      ST_READY: if (head_pop) nxt = ST_IDLE;
      ST_DROP:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      drop_o     <= 1'b0;
      drop_tmo_o <= 1'b0;
      send_ok_o  <= 1'b0;
    end else begin
      st         <= nxt;
      drop_o     <= (nxt == ST_DROP);
      drop_tmo_o <= tmo_n;
      send_ok_o  <= (nxt == ST_READY);
    end
  end

  p_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(drop_o && send_ok_o));
  p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    drop_o |=> !drop_o);
  p_tmo_sub_r8: assert property (@(posedge clk) disable iff (rst)
    drop_tmo_o |-> drop_o);
  p_nolimit_r6: assert property (@(posedge clk) disable iff (rst)
    drop_tmo_o |-> (en_q && lim_q != '0));
  p_offdrop_r7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && head_valid && off_now) |=> (drop_o && !drop_tmo_o));
  p_grant_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (send_ok_o && !head_pop) |=> send_ok_o);
  p_noflush_r5: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && !en_q) |=> !drop_o);
endmodule

// File: tb/utx_hol_flush_bench.sv
module utx_hol_flush_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        cfg_flush_en = 1'b0;
  logic [15:0] cfg_limit = '0;
  logic [7:0]  cfg_port_off = '0;
  logic        head_valid = 1'b0;
  logic [2:0]  head_phy = '0;
  logic        head_pop = 1'b0;
  logic        addr_phase = 1'b0;
  logic [2:0]  poll_phy = '0;
  logic        clav = 1'b0;
  logic        drop_o, drop_tmo_o, send_ok_o;

  utx_hol_flush u_utx_hol_flush (
    .clk(clk), .rst(rst), .cfg_flush_en(cfg_flush_en), .cfg_limit(cfg_limit),
    .cfg_port_off(cfg_port_off), .head_valid(head_valid), .head_phy(head_phy),
    .head_pop(head_pop), .addr_phase(addr_phase), .poll_phy(poll_phy),
    .clav(clav), .drop_o(drop_o), .drop_tmo_o(drop_tmo_o), .send_ok_o(send_ok_o)
  );

  int checks = 0, errors = 0;
  string tag = "R1";
  int q[$];
  bit [7:0] rdy = 8'hFF;
  bit [2:0] last_poll = '0;
  bit drop_seen = 0, tmo_seen = 0;
  int addr_pct = 30;
  bit cfg_churn = 0, push_on = 0, done = 0;

  // behavioural reference
  int m_mode = 0, m_cnt = 0, m_lim = 0, m_phy = 0, nmode = 0;
  bit m_en = 0, e_drop = 0, e_ok = 0, e_tmo = 0, ntmo = 0;
  int n_tmo = 0, n_off = 0, n_sent = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %0d exp %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_cnt = 0; e_drop = 0; e_ok = 0; e_tmo = 0;
    end else begin
      nmode = m_mode; ntmo = 0;
      if (m_mode == 0) begin
        if (head_valid) begin
          m_en = cfg_flush_en; m_lim = cfg_limit; m_phy = head_phy;
          nmode = (m_en && cfg_port_off[head_phy]) ? 4 : 1;
        end
      end else if (m_mode == 1) begin
        if (addr_phase && poll_phy == m_phy) begin m_cnt = 0; nmode = 2; end
      end else if (m_mode == 2) begin
        if (clav) nmode = 3;
        else if (addr_phase && poll_phy == m_phy) m_cnt = 0;
        else if (m_en && m_lim != 0 && m_cnt == m_lim) begin nmode = 4; ntmo = 1; end
        else m_cnt++;
      end else if (m_mode == 3) begin
        if (head_pop) nmode = 0;
      end else nmode = 0;
      m_mode = nmode;
      e_drop = (nmode == 4); e_ok = (nmode == 3); e_tmo = ntmo;
      if (drop_seen || head_pop) begin
        if (drop_seen && tmo_seen) n_tmo++;
        else if (drop_seen) n_off++;
        else n_sent++;
        void'(q.pop_front());
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk(drop_o == e_drop, {tag, " drop_o"}, drop_o, e_drop);
      chk(drop_tmo_o == e_tmo, {tag, " R8 drop_tmo_o"}, drop_tmo_o, e_tmo);
      chk(send_ok_o == e_ok, {tag, " R4 send_ok_o"}, send_ok_o, e_ok);
      chk(!(drop_o && send_ok_o), "R11 exclusive", drop_o, 0);
    end
    drop_seen = drop_o;
    tmo_seen  = drop_tmo_o;
    head_pop  = send_ok_o && ($urandom % 2 == 0);
    if (push_on && q.size() < 4 && ($urandom % 3 == 0)) q.push_back(int'($urandom % 8));
    head_valid = (q.size() > 0);
    head_phy   = (q.size() > 0) ? 3'(q[0]) : 3'd0;
    clav       = rdy[last_poll] && ($urandom % 4 != 0);
    addr_phase = ($urandom % 100) < addr_pct;
    poll_phy   = 3'($urandom % 8);
    if (addr_phase) last_poll = poll_phy;
    if (cfg_churn) begin
      cfg_flush_en = ($urandom % 4 != 0);
      cfg_limit    = 16'($urandom % 6);
      cfg_port_off = 8'($urandom);
    end
  end

  task automatic run(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic zero_counts();
    n_tmo = 0; n_off = 0; n_sent = 0;
  endtask

  initial begin
    run(4);
    @(negedge clk);
    chk(drop_o == 0 && send_ok_o == 0 && drop_tmo_o == 0, "R1 outputs in reset", drop_o | send_ok_o, 0);
    rst = 1'b0;
    push_on = 1;

    tag = "R2 R3 R9"; cfg_flush_en = 1; cfg_limit = 16'd6; rdy = 8'hFB; zero_counts();
    run(3000);
    chk(n_tmo > 0, "R3 timeouts seen", n_tmo, 1);
    tag = "R3 R9 limit1"; cfg_limit = 16'd1; run(1500);

    tag = "R4"; rdy = 8'hFF; cfg_limit = 16'd20; zero_counts(); run(2000);
    chk(n_sent > 0, "R4 cells granted", n_sent, 1);

    tag = "R7 R8"; cfg_port_off = 8'h24; zero_counts(); run(2000);
    chk(n_off > 0, "R7 bitmap drops", n_off, 1);
    chk(n_tmo == 0, "R8 no timeouts", n_tmo, 0);

    tag = "R5"; cfg_flush_en = 0; cfg_port_off = 8'hFF; cfg_limit = 16'd2; rdy = 8'hF7;
    run(300); zero_counts(); run(1500);
    chk(n_tmo == 0 && n_off == 0, "R5 no discards", n_tmo + n_off, 0);
    rdy = 8'hFF; run(300);

    tag = "R6"; cfg_flush_en = 1; cfg_port_off = 8'h00; cfg_limit = 16'd0; rdy = 8'hF7;
    run(300); zero_counts(); run(1500);
    chk(n_tmo == 0, "R6 zero limit no timeout", n_tmo, 0);
    rdy = 8'hFF; run(300);

    tag = "R10"; cfg_churn = 1; rdy = 8'hB5; zero_counts(); run(4000);
    chk(n_tmo + n_off + n_sent > 0, "R10 cells retired", n_tmo + n_off + n_sent, 1);
    cfg_churn = 0;

    done = 1;
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog R9 act %0d exp %0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule